// File: doc/BRIEF.md
# Four-Level Address Pin Decoder

This block works out how each of two address-select pins is wired: to ground, to the supply, to the serial data line or to the serial clock line. It does not sense the pins in any analog way. During each bus transmission, from a START event to the next STOP event, it compares each synchronized pin with the synchronized SDA and SCL lines on every clock cycle. When the STOP arrives it stores one of the four classes for each pin. The pair of classes gives the low four bits of a seven-bit slave address, and the rest of the port logic uses the same classes for per-pair pull-up enables and power-up output levels.

The decode is refreshed by every transmission on the bus, whether or not that transmission addresses this device, so a board can rewire the address without a power cycle. Until the first transmission has completed, each pin is classified from its plain logic level. A pin wired to an idle bus line therefore counts as tied high. START and STOP arrive as single-cycle pulses from the bus front end, in the same clock domain as the synchronized pins.

Top module: `addr_sel_decoder`

## Requirements
- R1: `dev_addr` equals the fixed prefix 3'b110 followed by `addr_low`, so it lies in 0x60 to 0x6F. `addr_low[3:2]` comes from the upper pin and `addr_low[1:0]` from the lower pin.
- R2: The upper pin codes as SCL = 2'b00, SDA = 2'b01, low = 2'b10, high = 2'b11.
- R3: The lower pin codes as low = 2'b00, high = 2'b01, SCL = 2'b10, SDA = 2'b11.
- R4: Until a pin has had its first committed decode, it is classified from its current level: 1 counts as high and 0 counts as low.
- R5: A decode commits on the clock edge where `bus_stop` is high inside an open transmission, and the outputs show it from the following cycle. A `bus_stop` pulse with no transmission open has no effect, and the outputs do not change while a transmission is in progress.
- R6: A pin is classed as SCL if it equalled SCL on every sampled cycle of the transmission and SCL changed at least once. Failing that, it is classed as SDA under the same test against SDA. Failing both, it is classed high or low if it held that level throughout. SCL is tested first.
- R7: If a pin fits no class, its previous decode is kept. Once decoded, a pin's outputs change only through a commit.
- R8: `pull_en[0]` and `dflt_hi[0]` belong to the lower pin's port pair, and `pull_en[1]` and `dflt_hi[1]` to the upper pin's pair. Each bit is 1 unless its pin is classed low.
- R9: A START seen while a transmission is already open (a repeated START) does not restart the comparison window. Evidence gathers from the first START up to the STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sda_s | input | 1 | Synchronized serial data line |
| scl_s | input | 1 | Synchronized serial clock line |
| pin_hi_s | input | 1 | Synchronized upper address-select pin |
| pin_lo_s | input | 1 | Synchronized lower address-select pin |
| bus_start | input | 1 | One-cycle START (or repeated START) event |
| bus_stop | input | 1 | One-cycle STOP event |
| addr_low | output | 4 | Decoded low address bits |
| dev_addr | output | 7 | Full seven-bit slave address |
| pull_en | output | 2 | Pull-up enable per port pair (bit 0 lower pin, bit 1 upper pin) |
| dflt_hi | output | 2 | Power-up level per port pair (1 = high) |

## Verification
The hardest cases to reach are those where the window logic has to reject evidence that looks valid in part. The first is a pin wired to SCL in a transmission where SCL never toggles. The second is a pin that is steady within each segment of a repeated-START transmission but differs between the segments. The bench builds the first from a START immediately followed by a STOP with no clock pulses, so the SCL-tied pin must decode as high. It builds the second by switching the pin's wiring between the two segments, right after the repeated START, so the pin must keep its earlier decode. The bench also checks that a wire change with no transmission, and a STOP with no transmission open, leave the outputs alone.

// File: rtl/asd_pkg.sv
// Shared types for the address-select decoder.
// Assumes exactly two four-level pins, each giving a two-bit code.
package asd_pkg;
    typedef enum logic [1:0] {
        CLS_HIGH = 2'd0,
        CLS_LOW  = 2'd1,
        CLS_SCL  = 2'd2,
        CLS_SDA  = 2'd3
    } pin_cls_t;
endpackage

// File: rtl/asd_window.sv
// Transmission window tracker: opens on a START, closes on a STOP.
// Assumes START and STOP are one-cycle pulses that never coincide.
// A START seen while the window is open keeps gathering evidence.
module asd_window (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_start,
    input  logic bus_stop,
    output logic win_clear,
    output logic win_sample,
    output logic win_commit
);
    logic open_q;

    // Window open flag: set on START, cleared on STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else if (bus_stop)
            open_q <= 1'b0;
        else if (bus_start)
            open_q <= 1'b1;
    end

    // Window strobes for the pin trackers.
    always_comb begin
        win_clear  = bus_start && !open_q;
        win_sample = open_q || bus_start;
        win_commit = bus_stop && open_q;
    end
endmodule

// File: rtl/asd_pin_tracker.sv
// Per-pin classifier. It compares the pin with SDA and SCL on every
// sampled cycle and commits a class at the end of the window.
// Assumes all inputs are synchronous to clk. Before the first commit
// the pin is classified from its present level.
module asd_pin_tracker
    import asd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin,
    input  logic     sda,
    input  logic     scl,
    input  logic     win_clear,
    input  logic     win_sample,
    input  logic     win_commit,
    output pin_cls_t cls_eff,
    output logic     seen
);
    logic     eq_sda, eq_scl, lv_hi, lv_lo, tg_sda, tg_scl;
    logic     prv_sda, prv_scl;
    pin_cls_t cls_q, cand;
    logic     cand_ok;

    // Previous line levels, used to detect toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prv_sda <= 1'b1;
            prv_scl <= 1'b1;
        end else begin
            prv_sda <= sda;
            prv_scl <= scl;
        end
    end

    // Evidence accumulators: seeded at a fresh START, narrowed each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_sda <= 1'b0;
            eq_scl <= 1'b0;
            lv_hi  <= 1'b0;
            lv_lo  <= 1'b0;
            tg_sda <= 1'b0;
            tg_scl <= 1'b0;
        end else if (win_clear) begin
            eq_sda <= (pin == sda);
            eq_scl <= (pin == scl);
            lv_hi  <= pin;
            lv_lo  <= !pin;
            tg_sda <= 1'b0;
            tg_scl <= 1'b0;
        end else if (win_sample) begin
            eq_sda <= eq_sda && (pin == sda);
            eq_scl <= eq_scl && (pin == scl);
            lv_hi  <= lv_hi && pin;
            lv_lo  <= lv_lo && !pin;
            tg_sda <= tg_sda || (sda != prv_sda);
            tg_scl <= tg_scl || (scl != prv_scl);
        end
    end

    // Candidate class, tested in priority order: SCL, SDA, high, low.
    always_comb begin
        cand_ok = 1'b1;
        cand    = CLS_LOW;
        if (eq_scl && tg_scl)
            cand = CLS_SCL;
        else if (eq_sda && tg_sda)
            cand = CLS_SDA;
        else if (lv_hi)
            cand = CLS_HIGH;
        else if (lv_lo)
            cand = CLS_LOW;
        else
            cand_ok = 1'b0;
    end

    // Committed class; a pin that fits no class keeps its old value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q <= CLS_HIGH;
            seen  <= 1'b0;
        end else if (win_commit && cand_ok) begin
            cls_q <= cand;
            seen  <= 1'b1;
        end
    end

    // Effective class: the level-based guess until the first commit.
    always_comb begin
        if (seen)
            cls_eff = cls_q;
        else
            cls_eff = pin ? CLS_HIGH : CLS_LOW;
    end
endmodule

// File: rtl/asd_code_map.sv
// Maps a pin class to its two address bits and its pair level.
// IS_UPPER selects the code table of the upper pin.
module asd_code_map
    import asd_pkg::*;
#(
    parameter bit IS_UPPER = 1'b0
) (
    input  pin_cls_t   cls,
    output logic [1:0] code,
    output logic       level_hi
);
    generate
        if (IS_UPPER) begin : g_upper
            // Upper pin code table.
            always_comb begin
                case (cls)
                    CLS_SCL:  code = 2'b00;
                    CLS_SDA:  code = 2'b01;
                    CLS_LOW:  code = 2'b10;
                    default:  code = 2'b11;
                endcase
            end
        end else begin : g_lower
            // Lower pin code table.
            always_comb begin
                case (cls)
                    CLS_LOW:  code = 2'b00;
                    CLS_HIGH: code = 2'b01;
                    CLS_SCL:  code = 2'b10;
                    default:  code = 2'b11;
                endcase
            end
        end
    endgenerate

    // Pull-ups and defaults are on for every class except low.
    always_comb level_hi = (cls != CLS_LOW);
endmodule

// File: rtl/addr_sel_decoder.sv
// Top of the four-level address-select decoder. Each pin's class is
// re-derived during every bus transmission and committed at STOP.
// Assumes synchronized inputs and one-cycle START/STOP pulses.
module addr_sel_decoder
    import asd_pkg::*;
#(
    parameter int          PREFIX_W = 3,
    parameter logic [2:0]  PREFIX   = 3'b110
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_s,
    input  logic       pin_hi_s,
    input  logic       pin_lo_s,
    input  logic       bus_start,
    input  logic       bus_stop,
    output logic [3:0] addr_low,
    output logic [6:0] dev_addr,
    output logic [1:0] pull_en,
    output logic [1:0] dflt_hi
);
    localparam int NUM_PINS = 2;
    localparam int CODE_W   = 2;
    localparam int ADDR_W   = NUM_PINS * CODE_W;

    logic               win_clear, win_sample, win_commit;
    logic [NUM_PINS-1:0] pins;
    logic [NUM_PINS-1:0] pin_seen;
    logic [NUM_PINS-1:0] lvl;
    logic [ADDR_W-1:0]   codes;

    // Pin vector: index 0 is the lower pin, index 1 the upper pin.
    always_comb pins = {pin_hi_s, pin_lo_s};

    asd_window u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .win_clear  (win_clear),
        .win_sample (win_sample),
        .win_commit (win_commit)
    );

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
            pin_cls_t cls;

            asd_pin_tracker u_trk (
                .clk        (clk),
                .rst_n      (rst_n),
                .pin        (pins[g]),
                .sda        (sda_s),
                .scl        (scl_s),
                .win_clear  (win_clear),
                .win_sample (win_sample),
                .win_commit (win_commit),
                .cls_eff    (cls),
                .seen       (pin_seen[g])
            );

            asd_code_map #(.IS_UPPER(g == 1)) u_map (
                .cls      (cls),
                .code     (codes[g*CODE_W +: CODE_W]),
                .level_hi (lvl[g])
            );
        end
    endgenerate

    // Output assembly.
    always_comb begin
        addr_low = codes;
        dev_addr = {PREFIX[PREFIX_W-1:0], codes};
        pull_en  = lvl;
        dflt_hi  = lvl;
    end
endmodule

// File: rtl/asd_checker.sv
// Property checker for addr_sel_decoder, attached by bind.
module asd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_stop,
    input logic       pin_lo_s,
    input logic       pin_hi_s,
    input logic [3:0] addr_low,
    input logic [1:0] pull_en,
    input logic [1:0] pin_seen
);
    // R7: once both pins are decoded, the address moves only after a STOP.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_seen == 2'b11 && !bus_stop) |=> $stable(addr_low));

    // R4: before its first commit, the lower pin's level sets its pair.
    a_r4_lo_level: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_seen[0] |-> (pull_en[0] == pin_lo_s));

    // R4: the same holds for the upper pin.
    a_r4_hi_level: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_seen[1] |-> (pull_en[1] == pin_hi_s));

    // R8: the lower pair is off exactly when the lower code is 2'b00.
    a_r8_lo_pull: assert property (@(posedge clk) disable iff (!rst_n)
        pull_en[0] == (addr_low[1:0] != 2'b00));

    // R8: the upper pair is off exactly when the upper code is 2'b10.
    a_r8_hi_pull: assert property (@(posedge clk) disable iff (!rst_n)
        pull_en[1] == (addr_low[3:2] != 2'b10));

    // R5: a pin becomes decoded only on a STOP edge.
    a_r5_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_seen[0]) |-> $past(bus_stop));
endmodule

bind addr_sel_decoder asd_checker u_chk (.*);

// File: tb/sim_addr_sel_decoder.sv
// Directed bench for addr_sel_decoder. Pin wiring mode per pin:
// 0 = ground, 1 = supply, 2 = SDA, 3 = SCL, 4 = erratic level.
module sim_addr_sel_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sda = 1'b1, scl = 1'b1;
    logic       bus_start = 1'b0, bus_stop = 1'b0;
    logic       pin_hi, pin_lo;
    logic [2:0] mode_hi = 3'd1, mode_lo = 3'd1;
    logic       glitch_v = 1'b1;
    logic [3:0] addr_low;
    logic [6:0] dev_addr, mid_addr;
    logic [1:0] pull_en, dflt_hi;
    int         checks = 0, errors = 0;

    always #5 clk = ~clk;

    // Pin wiring model.
    function automatic logic wire_pin(input logic [2:0] m);
        case (m)
            3'd0:    return 1'b0;
            3'd1:    return 1'b1;
            3'd2:    return sda;
            3'd3:    return scl;
            default: return glitch_v;
        endcase
    endfunction
    always_comb pin_hi = wire_pin(mode_hi);
    always_comb pin_lo = wire_pin(mode_lo);

    addr_sel_decoder u0 (
        .clk(clk), .rst_n(rst_n), .sda_s(sda), .scl_s(scl),
        .pin_hi_s(pin_hi), .pin_lo_s(pin_lo),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_low(addr_low), .dev_addr(dev_addr),
        .pull_en(pull_en), .dflt_hi(dflt_hi)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [3:0] a, input logic [1:0] lv);
        chk(req, dev_addr, {3'b110, a});
        chk(req, {5'd0, pull_en}, {5'd0, lv});
        chk(req, {5'd0, dflt_hi}, {5'd0, lv});
    endtask

    task automatic send_bits(input int nbits, input logic [7:0] data, input bit glitch);
        for (int i = 0; i < nbits; i++) begin
            if (glitch && i == 4) glitch_v = 1'b0;
            sda = (i < 8) ? data[7-i] : 1'b0;
            step(1); scl = 1'b1; step(1); scl = 1'b0; step(1);
        end
    endtask

    // One transmission; rs_mode >= 0 inserts a repeated START and rewires the lower pin.
    task automatic xfer(input int nbits, input logic [7:0] data, input int rs_mode, input bit glitch);
        glitch_v = 1'b1;
        sda = 1'b0; step(2);
        bus_start = 1'b1; step(1); bus_start = 1'b0;
        if (nbits > 0) begin
            scl = 1'b0; step(1);
            send_bits(nbits, data, glitch);
        end
        if (rs_mode >= 0) begin
            sda = 1'b1; step(1); scl = 1'b1; step(1); sda = 1'b0; step(2);
            bus_start = 1'b1; step(1); bus_start = 1'b0;
            mode_lo = rs_mode[2:0];
            scl = 1'b0; step(1);
            send_bits(9, ~data, 1'b0);
        end
        sda = 1'b0; step(1); scl = 1'b1; step(1);
        mid_addr = dev_addr;
        sda = 1'b1; step(1);
        bus_stop = 1'b1; step(1); bus_stop = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        step(1);
        chk_all("R4 reset state, both pins high", 4'b1101, 2'b11);
    endtask

    task automatic t_prefirst();
        mode_hi = 3'd2; mode_lo = 3'd0; step(2);
        chk_all("R4 idle SDA tie reads high, ground reads low", 4'b1100, 2'b10);
    endtask

    task automatic t_scl_sda();
        mode_hi = 3'd3; mode_lo = 3'd2;
        xfer(9, 8'hC4, -1, 1'b0);
        chk_all("R1 R2 R3 R6 upper SCL, lower SDA", 4'b0011, 2'b11);
    endtask

    task automatic t_sda_scl();
        mode_hi = 3'd2; mode_lo = 3'd3;
        xfer(9, 8'h5A, -1, 1'b0);
        chk("R5 no change before STOP", mid_addr, 7'h63);
        chk_all("R2 R3 R6 upper SDA, lower SCL", 4'b0110, 2'b11);
    endtask

    task automatic t_levels();
        mode_hi = 3'd0; mode_lo = 3'd1;
        xfer(9, 8'hD2, -1, 1'b0);
        chk_all("R8 upper low, lower high", 4'b1001, 2'b01);
        mode_hi = 3'd1; mode_lo = 3'd0;
        xfer(9, 8'h33, -1, 1'b0);
        chk_all("R8 upper high, lower low", 4'b1100, 2'b10);
    endtask

    task automatic t_idle_hold();
        mode_lo = 3'd3; mode_hi = 3'd0; step(3);
        chk_all("R7 rewiring without transmission ignored", 4'b1100, 2'b10);
        bus_stop = 1'b1; step(1); bus_stop = 1'b0; step(2);
        chk_all("R5 STOP with no open window ignored", 4'b1100, 2'b10);
    endtask

    task automatic t_glitch();
        mode_hi = 3'd3; mode_lo = 3'd4;
        xfer(9, 8'hA5, -1, 1'b1);
        chk_all("R7 erratic lower pin keeps ground code", 4'b0000, 2'b10);
    endtask

    task automatic t_no_clock();
        mode_hi = 3'd3; mode_lo = 3'd3;
        xfer(0, 8'h00, -1, 1'b0);
        chk_all("R6 SCL tie without SCL toggle reads high", 4'b1101, 2'b11);
    endtask

    task automatic t_repeated_start();
        mode_hi = 3'd0; mode_lo = 3'd2;
        xfer(9, 8'h96, -1, 1'b0);
        chk_all("R6 setup upper ground, lower SDA", 4'b1011, 2'b01);
        mode_hi = 3'd1; mode_lo = 3'd1;
        xfer(9, 8'h69, 0, 1'b0);
        chk_all("R9 repeated START keeps window, lower pin kept", 4'b1111, 2'b11);
    endtask

    initial begin
        step(3); rst_n = 1'b1; step(1);
        t_reset();
        t_prefirst();
        t_scl_sda();
        t_sda_scl();
        t_levels();
        t_idle_hold();
        t_glitch();
        t_no_clock();
        t_repeated_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R5 watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule